// File: doc/BRIEF.md
# Nibble-Wide Ethernet Transmit Framer

The block converts a stream of frame bytes (destination address through the end of the data field) into a complete Ethernet frame on a 4-bit media-independent transmit interface, one nibble per clock, for 10 and 100 Mb/s operation. It puts the preamble and start delimiter in front of the bytes. If padding is enabled it extends short frames with zero bytes. It appends the CRC-32 frame check sequence and then holds the line idle for the inter-frame gap. Frames longer than the standard size are cut short unless the oversize option is on.

Data enters over a valid/ready byte stream. `s_ready` is a one-cycle strobe, issued once for every byte the framer takes, and a byte moves on a cycle where `s_valid` and `s_ready` are both high. The line cannot stall once a frame has started. The source must therefore hold `s_valid` high with the next byte ready from the first cycle of a frame until the byte flagged by `s_last` has been taken. The framer starts a frame only when it sees `s_valid` high. It holds no copy of the frame. After a collision it pulses `tx_retry`, and the source then presents the same frame again from its first byte. After `frm_abort` the source drops that frame.

In half-duplex mode the framer defers while carrier sense is high and starts as soon as it falls (1-persistent). A collision during transmission replaces the rest of the frame with a jam. The framer then waits a random backoff and tries again, up to a fixed number of attempts. In full-duplex mode it ignores carrier and collision.

Top module: `mii_tx_framer`

## Requirements
- R1: A frame begins with fifteen nibbles of 0x5 followed by one nibble of 0xD. Every byte after that goes out low nibble first, with `mii_txen` high for the whole frame.
- R2: Bytes taken on `s_valid && s_ready` go out in the order received. `s_ready` is high for exactly one cycle per byte taken.
- R3: The last four bytes are the CRC-32 of the data and pad bytes: reflected polynomial 0xEDB88320, register preset to all ones, result inverted, least significant byte first.
- R4: When `cfg_pad_en` is high, a frame with fewer than MIN_BYTES (60) bytes is extended with 0x00 bytes to 60 before the CRC. When it is low, no bytes are added.
- R5: When `cfg_huge_en` is low, only the first MAX_BYTES (1514) bytes are sent, followed by the CRC over them. The surplus bytes are taken with `s_ready` held high until `s_last`, and no new frame starts before that.
- R6: When `cfg_huge_en` is high, frames longer than MAX_BYTES are sent whole.
- R7: After every frame or jam, `mii_txen` stays low for at least IFG_NIBBLES (24) cycles. A frame that is waiting starts after exactly 25 low cycles.
- R8: In half-duplex mode no frame starts while `mii_crs` is high. In full-duplex mode `mii_crs` and `mii_col` have no effect on the line.
- R9: A collision sampled in half-duplex mode while the framer transmits switches the line, from the next cycle, to 8 nibbles of 0xF. `tx_retry` pulses on the last of those nibbles.
- R10: After the n-th collision the framer waits k × SLOT_NIBBLES cycles, where k is random in 0 to 2^min(n,10)−1. The line is low for 26 + k × SLOT_NIBBLES cycles between the jam and the retried frame.
- R11: The jam that ends the 16th attempt pulses `frm_abort` instead of `tx_retry`. The attempt count then starts again for the next frame.
- R12: After reset `mii_txen`, `s_ready` and the status pulses are low. `frm_done` pulses on the last CRC nibble of a frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Transmit nibble clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_half_duplex | input | 1 | 1 = half duplex (defer, collision handling) |
| cfg_pad_en | input | 1 | Pad short frames to the minimum size |
| cfg_huge_en | input | 1 | Allow frames above MAX_BYTES |
| s_valid | input | 1 | Source has a byte |
| s_ready | output | 1 | Framer takes the byte this cycle |
| s_data | input | 8 | Frame byte |
| s_last | input | 1 | Byte is the last of the frame |
| mii_txd | output | 4 | Transmit nibble |
| mii_txen | output | 1 | Transmit enable |
| mii_crs | input | 1 | Carrier sense |
| mii_col | input | 1 | Collision detect |
| frm_done | output | 1 | Frame sent completely (pulse) |
| frm_abort | output | 1 | Frame abandoned after the attempt limit (pulse) |
| tx_retry | output | 1 | Source must present the frame again (pulse) |

## Verification
Most internal faults show up on the line within one frame. A bad nibble counter moves the start delimiter or shortens the CRC. A lost phase bit swaps nibbles or repeats a byte. A stale CRC register corrupts the last four bytes of the next frame. Each of these appears as a byte mismatch against the frame rebuilt from the input stream. Faults in the gap or backoff counters show only as timing: the number of low cycles between frames is wrong, which becomes visible when the next frame rises. A faulty attempt counter only appears after many collisions, as a missing or early abort pulse.

// File: rtl/mtf_pkg.sv
package mtf_pkg;

  typedef enum logic [2:0] {
    ST_IDLE, ST_PRE, ST_DATA, ST_PAD, ST_FCS, ST_JAM, ST_BACKOFF, ST_IFG
  } tx_state_e;

  // One nibble through the reflected CRC-32, bit 0 first.
  function automatic logic [31:0] crc_step4(input logic [31:0] c, input logic [3:0] d);
    logic [31:0] r;
    r = c;
    for (int i = 0; i < 4; i++) begin
      if (r[0] ^ d[i]) r = (r >> 1) ^ 32'hEDB88320;
      else             r = r >> 1;
    end
    return r;
  endfunction

endpackage

// File: rtl/mtf_crc.sv
module mtf_crc (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        init,
  input  logic        en,
  input  logic [3:0]  nib,
  output logic [31:0] fcs
);
  import mtf_pkg::*;

  logic [31:0] crc_q;

  always_ff @(posedge clk) begin
    if (!rst_n || init) crc_q <= '1;
    else if (en)        crc_q <= crc_step4(crc_q, nib);
  end

  assign fcs = ~crc_q;
endmodule

// File: rtl/mtf_backoff.sv
module mtf_backoff #(
  parameter int SLOT_NIBBLES = 128,
  parameter int EXP_CAP      = 10,
  parameter int AW           = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [AW-1:0] attempt,
  output logic          done
);
  localparam int SW = (SLOT_NIBBLES > 1) ? $clog2(SLOT_NIBBLES) : 1;

  logic [15:0]        lfsr;
  logic [EXP_CAP-1:0] slots, mask;
  logic [SW-1:0]      nib;
  logic [AW-1:0]      expn;
  logic               active;

  always_comb begin
    expn = (attempt > AW'(EXP_CAP)) ? AW'(EXP_CAP) : attempt;
    mask = (EXP_CAP'(1) << expn) - EXP_CAP'(1);
  end

  assign done = active && (slots == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lfsr   <= 16'hACE1;
      slots  <= '0;
      nib    <= '0;
      active <= 1'b0;
    end else begin
      lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      if (start) begin
        slots  <= lfsr[EXP_CAP-1:0] & mask;
        nib    <= '0;
        active <= 1'b1;
      end else if (active) begin
        if (slots == '0) active <= 1'b0;
        else if (nib == SW'(SLOT_NIBBLES - 1)) begin
          nib   <= '0;
          slots <= slots - EXP_CAP'(1);
        end else nib <= nib + SW'(1);
      end
    end
  end
endmodule

// File: rtl/mii_tx_framer.sv
module mii_tx_framer #(
  parameter int       MIN_BYTES    = 60,
  parameter int       MAX_BYTES    = 1514,
  parameter int       SLOT_NIBBLES = 128,
  parameter int       IFG_NIBBLES  = 24,
  parameter int       ATTEMPTS     = 16,
  parameter int       EXP_CAP      = 10,
  parameter bit [3:0] JAM_NIBBLE   = 4'hF
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cfg_half_duplex,
  input  logic       cfg_pad_en,
  input  logic       cfg_huge_en,
  input  logic       s_valid,
  output logic       s_ready,
  input  logic [7:0] s_data,
  input  logic       s_last,
  output logic [3:0] mii_txd,
  output logic       mii_txen,
  input  logic       mii_crs,
  input  logic       mii_col,
  output logic       frm_done,
  output logic       frm_abort,
  output logic       tx_retry
);
  import mtf_pkg::*;

  localparam int BCW  = 16;
  localparam int AW   = $clog2(ATTEMPTS + 1);
  localparam int CNTW = $clog2((IFG_NIBBLES > 16) ? IFG_NIBBLES : 16);

  tx_state_e       state;
  logic [CNTW-1:0] cnt;
  logic            phase, cur_last, drain;
  logic [7:0]      cur;
  logic [BCW-1:0]  byte_cnt, bc_next;
  logic [AW-1:0]   attempts, att_next;
  logic [31:0]     fcs;
  logic            on_line, colhit, trunc, last_byte, take, jam_end, bo_done;

  always_comb begin
    on_line   = state inside {ST_PRE, ST_DATA, ST_PAD, ST_FCS};
    colhit    = cfg_half_duplex && mii_col && on_line;
    bc_next   = byte_cnt + BCW'(1);
    trunc     = !cfg_huge_en && !cur_last && (bc_next == BCW'(MAX_BYTES));
    last_byte = cur_last || trunc;
    take      = !colhit && (((state == ST_PRE) && (cnt == CNTW'(15))) ||
                            ((state == ST_DATA) && phase && !last_byte));
    s_ready   = take || drain;
    jam_end   = (state == ST_JAM) && (cnt == CNTW'(7));
    att_next  = attempts + AW'(1);
    frm_abort = jam_end && (att_next == AW'(ATTEMPTS));
    tx_retry  = jam_end && !frm_abort;
    frm_done  = (state == ST_FCS) && (cnt == CNTW'(7)) && !colhit;
    mii_txen  = on_line || (state == ST_JAM);
    case (state)
      ST_PRE:  mii_txd = (cnt == CNTW'(15)) ? 4'hD : 4'h5;
      ST_DATA: mii_txd = phase ? cur[7:4] : cur[3:0];
      ST_FCS:  mii_txd = fcs[{cnt[2:0], 2'b00} +: 4];
      ST_JAM:  mii_txd = JAM_NIBBLE;
      default: mii_txd = 4'h0;
    endcase
  end

  mtf_crc u_crc (
    .clk  (clk),
    .rst_n(rst_n),
    .init (state == ST_IDLE),
    .en   ((state == ST_DATA) || (state == ST_PAD)),
    .nib  (mii_txd),
    .fcs  (fcs)
  );

  mtf_backoff #(.SLOT_NIBBLES(SLOT_NIBBLES), .EXP_CAP(EXP_CAP), .AW(AW)) u_backoff (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (tx_retry),
    .attempt(att_next),
    .done   (bo_done)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      cnt      <= '0;
      phase    <= 1'b0;
      cur      <= '0;
      cur_last <= 1'b0;
      byte_cnt <= '0;
      attempts <= '0;
      drain    <= 1'b0;
    end else begin
      if (drain && s_valid && s_last) drain <= 1'b0;
      if (colhit) begin
        state <= ST_JAM;
        cnt   <= '0;
      end else begin
        case (state)
          ST_IDLE: if (s_valid && !drain && !(cfg_half_duplex && mii_crs)) begin
            state <= ST_PRE;
            cnt   <= '0;
          end
          ST_PRE: begin
            cnt <= cnt + CNTW'(1);
            if (cnt == CNTW'(15)) begin
              state    <= ST_DATA;
              cur      <= s_data;
              cur_last <= s_last;
              phase    <= 1'b0;
              byte_cnt <= '0;
            end
          end
          ST_DATA: begin
            phase <= ~phase;
            if (phase) begin
              byte_cnt <= bc_next;
              if (last_byte) begin
                if (trunc) drain <= 1'b1;
                state <= (cfg_pad_en && (bc_next < BCW'(MIN_BYTES))) ? ST_PAD : ST_FCS;
                cnt   <= '0;
              end else begin
                cur      <= s_data;
                cur_last <= s_last;
              end
            end
          end
          ST_PAD: begin
            phase <= ~phase;
            if (phase) begin
              byte_cnt <= bc_next;
              if (bc_next == BCW'(MIN_BYTES)) begin
                state <= ST_FCS;
                cnt   <= '0;
              end
            end
          end
          ST_FCS: begin
            cnt <= cnt + CNTW'(1);
            if (cnt == CNTW'(7)) begin
              state    <= ST_IFG;
              cnt      <= '0;
              attempts <= '0;
            end
          end
          ST_JAM: begin
            cnt <= cnt + CNTW'(1);
            if (jam_end) begin
              cnt <= '0;
              if (frm_abort) begin
                attempts <= '0;
                state    <= ST_IFG;
              end else begin
                attempts <= att_next;
                state    <= ST_BACKOFF;
              end
            end
          end
          ST_BACKOFF: if (bo_done) begin
            state <= ST_IFG;
            cnt   <= '0;
          end
          ST_IFG: begin
            cnt <= cnt + CNTW'(1);
            if (cnt == CNTW'(IFG_NIBBLES - 1)) state <= ST_IDLE;
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/mii_tx_framer_chk.sv
module mii_tx_framer_chk #(
  parameter int       IFG_NIBBLES = 24,
  parameter bit [3:0] JAM_NIBBLE  = 4'hF
) (
  input logic       clk,
  input logic       rst_n,
  input logic       cfg_half_duplex,
  input logic       mii_crs,
  input logic [3:0] mii_txd,
  input logic       mii_txen,
  input logic       frm_done,
  input logic       frm_abort,
  input logic       tx_retry
);
  localparam int GW = $clog2(IFG_NIBBLES + 2);

  logic [GW-1:0] low_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) low_cnt <= GW'(IFG_NIBBLES);
    else if (mii_txen) low_cnt <= '0;
    else if (low_cnt < GW'(IFG_NIBBLES)) low_cnt <= low_cnt + GW'(1);
  end

  assert_preamble_start_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mii_txen) |-> (mii_txd == 4'h5));

  assert_gap_min_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mii_txen) |-> (low_cnt >= GW'(IFG_NIBBLES)));

  assert_defer_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_half_duplex && mii_crs && !mii_txen) |=> !mii_txen);

  assert_full_duplex_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_half_duplex |-> (!tx_retry && !frm_abort));

  assert_retry_on_jam_R9: assert property (@(posedge clk) disable iff (!rst_n)
    tx_retry |-> (mii_txen && (mii_txd == JAM_NIBBLE)));

  assert_abort_ends_R11: assert property (@(posedge clk) disable iff (!rst_n)
    frm_abort |=> !mii_txen);

  assert_done_last_nibble_R12: assert property (@(posedge clk) disable iff (!rst_n)
    frm_done |-> mii_txen ##1 !mii_txen);
endmodule

bind mii_tx_framer mii_tx_framer_chk #(.IFG_NIBBLES(IFG_NIBBLES), .JAM_NIBBLE(JAM_NIBBLE)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .cfg_half_duplex(cfg_half_duplex),
  .mii_crs        (mii_crs),
  .mii_txd        (mii_txd),
  .mii_txen       (mii_txen),
  .frm_done       (frm_done),
  .frm_abort      (frm_abort),
  .tx_retry       (tx_retry)
);

// File: tb/mii_tx_framer_bench.sv
`timescale 1ns/1ps
module mii_tx_framer_bench;
  localparam int SLOT = 4;
  localparam int MAXB = 1514;
  localparam int MINB = 60;

  logic clk = 1'b0, rst_n = 1'b0;
  logic half = 1'b0, pad = 1'b1, huge = 1'b0;
  logic s_valid = 1'b0, s_last = 1'b0, crs = 1'b0, col = 1'b0;
  logic [7:0] s_data = 8'h00;
  logic s_ready, txen, frm_done, frm_abort, tx_retry;
  logic [3:0] txd;

  always #2 clk = ~clk;

  mii_tx_framer #(.SLOT_NIBBLES(SLOT)) u_mii_tx_framer (
    .clk(clk), .rst_n(rst_n), .cfg_half_duplex(half), .cfg_pad_en(pad),
    .cfg_huge_en(huge), .s_valid(s_valid), .s_ready(s_ready), .s_data(s_data),
    .s_last(s_last), .mii_txd(txd), .mii_txen(txen), .mii_crs(crs), .mii_col(col),
    .frm_done(frm_done), .frm_abort(frm_abort), .tx_retry(tx_retry)
  );

  int checks = 0, fails = 0;
  logic [7:0] frm [0:2047];
  int frm_len = 0;
  logic [7:0] exp_b[$];
  int exp_len[$];
  string exp_tag[$];
  int frames_seen = 0, retries = 0, aborts = 0, dones = 0;
  int gap_arr [0:63];

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] crc_byte(input logic [31:0] c, input logic [7:0] b);
    logic [31:0] r = c;
    for (int k = 0; k < 8; k++) r = (r[0] ^ b[k]) ? ((r >> 1) ^ 32'hEDB88320) : (r >> 1);
    return r;
  endfunction

  task automatic fill(input int len, input int seed);
    frm_len = len;
    for (int i = 0; i < len; i++) frm[i] = 8'((i * 7 + seed) & 255);
  endtask

  task automatic push_expect(input string tag);
    int sent, total;
    logic [31:0] c;
    logic [7:0] b;
    sent  = (!huge && frm_len > MAXB) ? MAXB : frm_len;
    total = (pad && sent < MINB) ? MINB : sent;
    for (int i = 0; i < 7; i++) exp_b.push_back(8'h55);
    exp_b.push_back(8'hD5);
    c = 32'hFFFFFFFF;
    for (int i = 0; i < total; i++) begin
      b = (i < sent) ? frm[i] : 8'h00;
      exp_b.push_back(b);
      c = crc_byte(c, b);
    end
    c = ~c;
    for (int i = 0; i < 4; i++) exp_b.push_back(c[8*i +: 8]);
    exp_len.push_back(total + 12);
    exp_tag.push_back(tag);
  endtask

  task automatic push_jam(input string tag);
    exp_len.push_back(0);
    exp_tag.push_back(tag);
  endtask

  // Source: replays on tx_retry, drops the frame on frm_abort.
  task automatic drive_frame();
    int idx = 0;
    bit consumed = 0, fin = 0, r, rt, ab, dn;
    @(posedge clk); #1;
    s_valid = 1'b1; s_data = frm[0]; s_last = (frm_len == 1);
    while (!fin) begin
      @(negedge clk);
      r = s_ready; rt = tx_retry; ab = frm_abort; dn = frm_done;
      @(posedge clk); #1;
      if (r && !consumed) begin
        if (idx == frm_len - 1) consumed = 1;
        else idx++;
      end
      if (rt) begin idx = 0; consumed = 0; end
      if (ab || (dn && consumed)) fin = 1;
      s_valid = !consumed && !fin;
      s_data  = frm[idx];
      s_last  = (idx == frm_len - 1);
    end
    s_valid = 1'b0;
  endtask

  // Monitor: rebuilds each burst of txen and compares it with the scoreboard.
  initial begin
    logic [3:0] nib[$];
    int low = 0, len, bad_at;
    bit prev = 0, ok;
    string tag;
    forever begin
      @(negedge clk);
      if (rst_n) begin
        retries += int'(tx_retry);
        aborts  += int'(frm_abort);
        dones   += int'(frm_done);
        if (txen) begin
          if (!prev && frames_seen < 64) gap_arr[frames_seen] = low;
          nib.push_back(txd);
          low = 0;
        end else begin
          if (prev) begin
            if (exp_len.size() == 0) check(0, "R2", "unexpected frame", nib.size(), 0);
            else begin
              len = exp_len.pop_front();
              tag = exp_tag.pop_front();
              if (len == 0) begin
                ok = nib.size() >= 9;
                for (int i = 1; i <= 8 && ok; i++) if (nib[nib.size() - i] != 4'hF) ok = 0;
                check(ok, tag, "jam nibbles 0xF at burst end", nib.size(), 9);
              end else begin
                ok = (nib.size() == 2 * len);
                bad_at = -1;
                for (int i = 0; i < len; i++) begin
                  if (ok && bad_at < 0 && {nib[2*i+1], nib[2*i]} != exp_b[0]) bad_at = i;
                  void'(exp_b.pop_front());
                end
                if (!ok) check(0, tag, "frame nibble count", nib.size(), 2 * len);
                else check(bad_at < 0, tag, "first wrong byte index", bad_at, -1);
              end
            end
            frames_seen++;
            nib.delete();
            low = 1;
          end else low++;
        end
        prev = txen;
      end
    end
  end

  initial begin
    #(4 * 180000);
    check(0, "R12", "watchdog expired", 0, 1);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    int f0, r0, a0, g;
    bit seen;
    repeat (3) @(negedge clk);
    check(txen == 1'b0, "R12", "txen in reset", int'(txen), 0);
    check(s_ready == 1'b0, "R12", "s_ready in reset", int'(s_ready), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!txen && !frm_done && !tx_retry && !frm_abort, "R12", "idle after reset", int'(txen), 0);

    // Short frame padded (R1 R3 R4)
    pad = 1; fill(20, 3); push_expect("R4 R1 R3 padded");
    drive_frame(); repeat (30) @(negedge clk);
    // Short frame without padding (R4)
    pad = 0; fill(20, 9); push_expect("R4 unpadded");
    drive_frame(); repeat (30) @(negedge clk);

    // Back-to-back frames (R2 R7)
    pad = 1; fill(100, 1); push_expect("R2 frame A");
    drive_frame();
    fill(70, 5); push_expect("R2 frame B");
    f0 = frames_seen + 1;
    drive_frame(); repeat (30) @(negedge clk);
    check(gap_arr[f0] == 25, "R7", "back-to-back low cycles", gap_arr[f0], 25);

    // Oversize truncated then passed (R5 R6)
    huge = 0; fill(1518, 2); push_expect("R5 truncated");
    drive_frame(); repeat (30) @(negedge clk);
    huge = 1; fill(1518, 4); push_expect("R6 oversize sent");
    drive_frame(); repeat (30) @(negedge clk);
    huge = 0;

    // Full duplex ignores carrier and collision (R8)
    half = 0; fill(64, 6); push_expect("R8 full duplex ignores crs/col");
    fork
      drive_frame();
      begin
        wait (txen); repeat (10) @(negedge clk);
        crs = 1; col = 1; repeat (20) @(negedge clk); crs = 0; col = 0;
      end
    join
    repeat (30) @(negedge clk);

    // Half duplex defers on carrier (R8)
    half = 1; crs = 1; fill(64, 8); push_expect("R8 deferred frame");
    seen = 0;
    fork
      drive_frame();
      begin
        repeat (40) begin @(negedge clk); if (txen) seen = 1; end
        check(!seen, "R8", "txen while carrier high", int'(seen), 0);
        crs = 0;
      end
    join
    repeat (30) @(negedge clk);

    // Single collision: jam, retry, backoff (R9 R10)
    fill(64, 11); push_jam("R9 jam"); push_expect("R9 replayed frame");
    r0 = retries; f0 = frames_seen + 1;
    fork
      drive_frame();
      begin
        wait (txen); repeat (40) @(negedge clk);
        col = 1; @(negedge clk); col = 0;
      end
    join
    repeat (30) @(negedge clk);
    check(retries - r0 == 1, "R9", "retry pulses", retries - r0, 1);
    g = gap_arr[f0];
    check(g == 26 || g == 26 + SLOT, "R10", "low cycles after first jam", g, 26);

    // Persistent collision: abort after 16 attempts (R11)
    r0 = retries; a0 = aborts; fill(64, 13);
    for (int i = 0; i < 16; i++) push_jam("R11 jam attempt");
    col = 1;
    drive_frame();
    col = 0;
    repeat (30) @(negedge clk);
    check(aborts - a0 == 1, "R11", "abort pulses", aborts - a0, 1);
    check(retries - r0 == 15, "R11", "retry pulses before abort", retries - r0, 15);

    // Next frame after abort is sent normally (R11 R12)
    half = 0; fill(30, 15); push_expect("R11 frame after abort");
    drive_frame(); repeat (30) @(negedge clk);

    check(exp_len.size() == 0, "R2", "frames still expected", exp_len.size(), 0);
    check(dones == 10, "R12", "done pulses", dones, 10);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule